// File: doc/BRIEF.md
# ADC Two-Point Temperature Calculator

This block turns a stream of raw converter status words into one signed temperature reading. A start pulse begins a measurement. The block drives a test-point select line low and consumes samples until it has a first mean. It then drives the select line high and takes a second mean. Each mean is the sum of a fixed number of flagged 10-bit sample values, scaled by 1000 and divided by the sample count. After each select setting, the first flagged samples are thrown away so that the analog path can settle.

The two means are combined through a ratio and a fixed quadratic with truncating signed integer steps. One shared sequential divider does all seven divisions. A single-cycle done pulse marks a fresh temperature value. A single-cycle error pulse marks a measurement that a collection watchdog abandoned.

The sample input is valid/ready. A word is taken on a rising clock edge where both `smp_valid_i` and `smp_ready_o` are high. `smp_ready_o` is high only while a select phase is acquiring. It does not depend on `smp_valid_i`. The source may lower valid at any time and must hold the word stable while valid is high and ready is low. Each transfer counts as one read, flagged or not.

Top module: `thermo_calc`

## Requirements
- R1: A sample word carries its flag in bit 10 and its value in bits 9:0. Only flagged words count as samples, but every accepted transfer counts as a read. `smp_ready_o` is low outside the two acquisition phases, and after the last sample is accepted it stays low until the next start.
- R2: `sel_o` is 0 while the first mean is acquired and 1 while the second is acquired. It returns to 0 when the second acquisition ends, or at an error.
- R3: After each select setting, the first DROP flagged samples (default 2) are discarded, and no further reads are made for that phase once its mean is complete.
- R4: If DISC_LIMIT reads pass in a discard phase without DROP flagged samples, discarding stops and collection begins with the next read.
- R5: Each mean is the sum of NSAMP flagged values (default 80) times 1000, divided by NSAMP and truncated.
- R6: If the second mean divided by 1000 is zero, the second mean is replaced by 1000 before the ratio is formed.
- R7: With m1 and m2 the means, the block computes a = (m2 - m1) / (m2 / 1000), then temp = ((-559*a)/1000*a)/1000 + (1379*a)/1000 - 458. Every division is signed and truncates toward zero.
- R8: `done_o` is a single-cycle pulse that rises exactly 7*(DW+2)+2 cycles after the final accepted sample (352 for DW=48). `temp_o` holds its value until the next done pulse.
- R9: If COLL_LIMIT reads pass in a collection phase without NSAMP flagged samples, `err_o` pulses for one cycle, `done_o` stays low, `temp_o` is unchanged and the block returns to idle.
- R10: A start pulse during a measurement is ignored: the measurement produces one result and no second run follows.
- R11: After reset, `temp_o` is 0 and `done_o`, `err_o`, `smp_ready_o` and `sel_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a measurement (sampled when idle) |
| smp_valid_i | input | 1 | Sample word valid |
| smp_data_i | input | 11 | Bit 10 flag, bits 9:0 value |
| smp_ready_o | output | 1 | Block accepts a sample word |
| sel_o | output | 1 | Analog test-point select |
| temp_o | output | TW | Signed temperature result |
| done_o | output | 1 | One-cycle pulse, new temperature |
| err_o | output | 1 | One-cycle pulse, collection watchdog expired |

## Verification
The bench counts clock edges and records the edge of the last accepted sample. It samples on falling edges and requires `done_o` to appear exactly 7*(DW+2)+2 edges after that sample, and to be low again one cycle later. Read counts per select value are checked once the result is out, and the bench then waits several hundred more cycles to confirm there are no stray transfers and no extra done pulse. Means, ratio and quadratic are recomputed in the bench from the generated words with 64-bit integer arithmetic. Patterns cover gapped valid strobes, sparse flags, a negative ratio, the zero-mean substitution, the discard give-up and the collection watchdog.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACQ0, ST_ACQ1, ST_LAUNCH, ST_WAIT, ST_FIN
  } top_state_t;

  typedef enum logic [1:0] {
    A_IDLE, A_DISC, A_COLL
  } acq_phase_t;

  // arithmetic steps run in this order on the shared divider
  localparam logic [2:0] STEP_M1  = 3'd0;
  localparam logic [2:0] STEP_M2  = 3'd1;
  localparam logic [2:0] STEP_K   = 3'd2;
  localparam logic [2:0] STEP_A   = 3'd3;
  localparam logic [2:0] STEP_T1  = 3'd4;
  localparam logic [2:0] STEP_T2  = 3'd5;
  localparam logic [2:0] STEP_T3  = 3'd6;
  localparam int         NUM_STEPS = 7;

  localparam int SCALE   = 1000;
  localparam int COEF_SQ = -559;
  localparam int COEF_LN = 1379;
  localparam int COEF_K0 = -458;
endpackage

// File: rtl/thermo_div.sv
module thermo_div #(
  parameter int DW = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic signed [DW-1:0] num_i,
  input  logic signed [DW-1:0] den_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic signed [DW-1:0] quo_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] quo_q, den_q;
  logic [DW:0]   rem_q;
  logic [CW-1:0] cnt_q;
  logic          neg_q;

  logic [DW:0]   shifted, nrem;
  logic [DW-1:0] nquo;
  logic          ge;

  always_comb begin
    shifted = {rem_q[DW-1:0], quo_q[DW-1]};
    ge      = shifted >= {1'b0, den_q};
    nrem    = ge ? shifted - {1'b0, den_q} : shifted;
    nquo    = {quo_q[DW-2:0], ge};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      neg_q  <= 1'b0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      quo_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        quo_q  <= num_i[DW-1] ? DW'(-num_i) : DW'(num_i);
        den_q  <= den_i[DW-1] ? DW'(-den_i) : DW'(den_i);
        neg_q  <= num_i[DW-1] ^ den_i[DW-1];
        rem_q  <= '0;
        cnt_q  <= CW'(DW);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        rem_q <= nrem;
        quo_q <= nquo;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          quo_o  <= neg_q ? -$signed(nquo) : $signed(nquo);
        end
      end
    end
  end

  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !start_i);
endmodule

// File: rtl/thermo_acq.sv
module thermo_acq
  import thermo_pkg::*;
#(
  parameter int NSAMP      = 80,
  parameter int DROP       = 2,
  parameter int DISC_LIMIT = 100000,
  parameter int COLL_LIMIT = 1000000,
  parameter int SW         = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          valid_i,
  input  logic [10:0]   data_i,
  output logic          ready_o,
  output logic          fin_o,
  output logic          err_o,
  output logic [SW-1:0] sum_o
);
  localparam int MAXL = (DISC_LIMIT > COLL_LIMIT) ? DISC_LIMIT : COLL_LIMIT;
  localparam int RW   = $clog2(MAXL + 1);
  localparam int CW   = $clog2(NSAMP + 1);
  localparam int DCW  = $clog2(DROP + 1);

  acq_phase_t     phase;
  logic [RW-1:0]  rd_q;
  logic [CW-1:0]  vcnt_q;
  logic [DCW-1:0] dcnt_q;
  logic [SW-1:0]  acc_q;

  logic       hs, flag;
  logic [9:0] val;

  assign ready_o = (phase != A_IDLE);
  assign hs      = valid_i && ready_o;
  assign flag    = data_i[10];
  assign val     = data_i[9:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= A_IDLE;
      rd_q   <= '0;
      vcnt_q <= '0;
      dcnt_q <= '0;
      acc_q  <= '0;
      sum_o  <= '0;
      fin_o  <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      err_o <= 1'b0;
      unique case (phase)
        A_IDLE: if (start_i) begin
          phase  <= A_DISC;
          rd_q   <= '0;
          vcnt_q <= '0;
          dcnt_q <= '0;
          acc_q  <= '0;
        end
        A_DISC: if (hs) begin
          if ((flag && dcnt_q == DCW'(DROP - 1)) || rd_q == RW'(DISC_LIMIT - 1)) begin
            phase <= A_COLL;
            rd_q  <= '0;
          end else begin
            rd_q <= rd_q + 1'b1;
            if (flag) dcnt_q <= dcnt_q + 1'b1;
          end
        end
        A_COLL: if (hs) begin
          if (flag && vcnt_q == CW'(NSAMP - 1)) begin
            sum_o <= acc_q + SW'(val);
            fin_o <= 1'b1;
            phase <= A_IDLE;
          end else if (rd_q == RW'(COLL_LIMIT - 1)) begin
            err_o <= 1'b1;
            phase <= A_IDLE;
          end else begin
            rd_q <= rd_q + 1'b1;
            if (flag) begin
              acc_q  <= acc_q + SW'(val);
              vcnt_q <= vcnt_q + 1'b1;
            end
          end
        end
        default: phase <= A_IDLE;
      endcase
    end
  end

  p_vcnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt_q < CW'(NSAMP));
  p_start_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (phase == A_IDLE));
  p_fin_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin_o && err_o));
endmodule

// File: rtl/thermo_calc.sv
module thermo_calc
  import thermo_pkg::*;
#(
  parameter int NSAMP      = 80,
  parameter int DROP       = 2,
  parameter int DISC_LIMIT = 100000,
  parameter int COLL_LIMIT = 1000000,
  parameter int DW         = 48,
  parameter int TW         = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 smp_valid_i,
  input  logic [10:0]          smp_data_i,
  output logic                 smp_ready_o,
  output logic                 sel_o,
  output logic signed [TW-1:0] temp_o,
  output logic                 done_o,
  output logic                 err_o
);
  localparam int SW = $clog2(NSAMP * 1023 + 1);
  localparam logic signed [DW-1:0] SCALE_W = DW'(SCALE);
  localparam logic signed [DW-1:0] NSAMP_W = DW'(NSAMP);
  localparam logic signed [DW-1:0] SQ_W    = DW'(COEF_SQ);
  localparam logic signed [DW-1:0] LN_W    = DW'(COEF_LN);
  localparam logic signed [DW-1:0] K0_W    = DW'(COEF_K0);

  top_state_t state;
  logic [2:0] step_q;
  logic       acq_start_q;
  logic       acq_fin, acq_err;
  logic [SW-1:0] acq_sum;
  logic [SW-1:0] sum0_q, sum1_q;
  logic signed [DW-1:0] m1_q, m2_q, k_q, a_q, t1_q, t2_q, t3_q;
  logic signed [DW-1:0] div_num, div_den, div_q;
  logic div_start, div_busy, div_done;

  thermo_acq #(
    .NSAMP(NSAMP), .DROP(DROP), .DISC_LIMIT(DISC_LIMIT),
    .COLL_LIMIT(COLL_LIMIT), .SW(SW)
  ) acq_i (
    .clk(clk), .rst_n(rst_n), .start_i(acq_start_q),
    .valid_i(smp_valid_i), .data_i(smp_data_i), .ready_o(smp_ready_o),
    .fin_o(acq_fin), .err_o(acq_err), .sum_o(acq_sum)
  );

  thermo_div #(.DW(DW)) div_i (
    .clk(clk), .rst_n(rst_n), .start_i(div_start),
    .num_i(div_num), .den_i(div_den),
    .busy_o(div_busy), .done_o(div_done), .quo_o(div_q)
  );

  assign div_start = (state == ST_LAUNCH);

  always_comb begin
    div_num = SCALE_W;
    div_den = SCALE_W;
    unique case (step_q)
      STEP_M1: begin div_num = $signed(DW'(sum0_q)) * SCALE_W; div_den = NSAMP_W; end
      STEP_M2: begin div_num = $signed(DW'(sum1_q)) * SCALE_W; div_den = NSAMP_W; end
      STEP_K:  div_num = m2_q;
      STEP_A:  begin div_num = m2_q - m1_q; div_den = k_q; end
      STEP_T1: div_num = SQ_W * a_q;
      STEP_T2: div_num = t1_q * a_q;
      STEP_T3: div_num = LN_W * a_q;
      default: div_num = SCALE_W;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      step_q      <= '0;
      acq_start_q <= 1'b0;
      sel_o       <= 1'b0;
      sum0_q      <= '0;
      sum1_q      <= '0;
      m1_q <= '0; m2_q <= '0; k_q <= '0; a_q <= '0;
      t1_q <= '0; t2_q <= '0; t3_q <= '0;
      temp_o      <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      acq_start_q <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          state       <= ST_ACQ0;
          sel_o       <= 1'b0;
          acq_start_q <= 1'b1;
        end
        ST_ACQ0: if (acq_err) begin
          err_o <= 1'b1;
          state <= ST_IDLE;
        end else if (acq_fin) begin
          sum0_q      <= acq_sum;
          sel_o       <= 1'b1;
          acq_start_q <= 1'b1;
          state       <= ST_ACQ1;
        end
        ST_ACQ1: if (acq_err) begin
          err_o <= 1'b1;
          sel_o <= 1'b0;
          state <= ST_IDLE;
        end else if (acq_fin) begin
          sum1_q <= acq_sum;
          sel_o  <= 1'b0;
          step_q <= STEP_M1;
          state  <= ST_LAUNCH;
        end
        ST_LAUNCH: state <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          unique case (step_q)
            STEP_M1: m1_q <= div_q;
            STEP_M2: m2_q <= div_q;
            STEP_K: begin
              if (div_q == '0) begin
                k_q  <= DW'(1);
                m2_q <= SCALE_W;
              end else begin
                k_q <= div_q;
              end
            end
            STEP_A:  a_q  <= div_q;
            STEP_T1: t1_q <= div_q;
            STEP_T2: t2_q <= div_q;
            default: t3_q <= div_q;
          endcase
          step_q <= step_q + 1'b1;
          state  <= (step_q == 3'(NUM_STEPS - 1)) ? ST_FIN : ST_LAUNCH;
        end
        ST_FIN: begin
          temp_o <= TW'(t2_q + t3_q + K0_W);
          done_o <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !smp_ready_o);
  p_sel_hi_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready_o && sel_o) |-> (state == ST_ACQ1));
  p_sel_lo_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready_o && !sel_o) |-> (state == ST_ACQ0));
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ACQ1 || state == ST_LAUNCH || state == ST_WAIT) && start_i)
      |=> (state != ST_ACQ0));
  p_temp_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> $stable(temp_o) || done_o);
endmodule

// File: tb/thermo_calc_tb.sv
module thermo_calc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSAMP = 80;
  localparam int DROP  = 2;
  localparam int DLIM  = 40;
  localparam int CLIM  = 400;
  localparam int DW    = 48;
  localparam int TW    = 32;
  localparam int LAT   = 7 * (DW + 2) + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic smp_valid_i = 1'b0;
  logic [10:0] smp_data_i = '0;
  logic smp_ready_o, sel_o, done_o, err_o;
  logic signed [TW-1:0] temp_o;

  int n_checks = 0;
  int n_fail = 0;
  int cur_pat = 0;
  bit gap_en = 1'b0;
  bit idx_clr = 1'b0;
  int idx0 = 0, idx1 = 0;
  longint ec = 0, last_hs = 0;
  longint last_temp = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  thermo_calc #(
    .NSAMP(NSAMP), .DROP(DROP), .DISC_LIMIT(DLIM), .COLL_LIMIT(CLIM),
    .DW(DW), .TW(TW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .smp_ready_o(smp_ready_o), .sel_o(sel_o), .temp_o(temp_o),
    .done_o(done_o), .err_o(err_o)
  );

  // word generator: bit 10 flag, bits 9:0 value
  function automatic logic [10:0] word(int pat, bit s, int i);
    int v;
    bit f;
    v = 0;
    f = 1'b1;
    case (pat)
      0: v = s ? 600 : 300;
      1: begin v = s ? (i * 13 + 500) % 1024 : (i * 7 + 100) % 1024; f = (i % 4) != 3; end
      2: begin v = s ? 200 + i % 50 : 900; f = (i % 5) != 0; end
      3: v = s ? 0 : 5;
      4: begin
        if (!s) begin v = (i * 3) % 1024; f = (i == 3) || (i >= 50); end
        else v = 700;
      end
      5: begin v = 400; f = s ? 1'b1 : ((i % 6) == 0); end
      default: v = 1023;
    endcase
    return {f, v[9:0]};
  endfunction

  // one select phase of the reference model
  task automatic model_phase(input int pat, input bit s, output longint sum,
                             output int reads, output bit err);
    int i, nf, c, cnt;
    logic [10:0] w;
    i = 0; nf = 0; sum = 0; err = 1'b0;
    while (1) begin
      w = word(pat, s, i); i++;
      if (w[10]) nf++;
      if (nf == DROP || i == DLIM) break;
    end
    c = 0; cnt = 0;
    while (1) begin
      w = word(pat, s, i); i++; c++;
      if (w[10]) begin sum += w[9:0]; cnt++; end
      if (cnt == NSAMP) break;
      if (c == CLIM) begin err = 1'b1; break; end
    end
    reads = i;
  endtask

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    ec <= ec + 1;
    if (idx_clr) begin
      idx0 <= 0; idx1 <= 0;
    end else if (smp_valid_i && smp_ready_o) begin
      last_hs <= ec + 1;
      if (sel_o) idx1 <= idx1 + 1; else idx0 <= idx0 + 1;
    end
  end

  always @(negedge clk) begin
    smp_valid_i = !(gap_en && (ec % 5) == 2);
    smp_data_i  = word(cur_pat, sel_o, sel_o ? idx1 : idx0);
  end

  task automatic run(input int pat, input bit gap, input int inj, input string tag);
    longint s0, s1, m1, m2, k, a, t;
    int r0, r1, extra, i0, i1;
    bit e0, e1, exp_err, got_done, got_err;
    longint lat;
    model_phase(pat, 1'b0, s0, r0, e0);
    model_phase(pat, 1'b1, s1, r1, e1);
    exp_err = e0 || e1;
    if (e0) r1 = 0;
    t = last_temp;
    if (!exp_err) begin
      m1 = s0 * 1000 / NSAMP;
      m2 = s1 * 1000 / NSAMP;
      k = m2 / 1000;
      if (k == 0) begin m2 = 1000; k = 1; end
      a = (m2 - m1) / k;
      t = ((-559 * a) / 1000 * a) / 1000 + (1379 * a) / 1000 - 458;
    end
    @(negedge clk);
    cur_pat = pat; gap_en = gap; idx_clr = 1'b1;
    @(negedge clk);
    idx_clr = 1'b0; start_i = 1'b1;
    got_done = 1'b0; got_err = 1'b0; lat = 0;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      start_i = (inj != 0 && c == inj);
      if (done_o || err_o) begin
        got_done = done_o; got_err = err_o; lat = ec - last_hs;
        break;
      end
    end
    start_i = 1'b0;
    check({tag, " R9 error flag"}, got_err, exp_err);
    check({tag, " R9 done vs error"}, got_done, !exp_err);
    if (!exp_err) check({tag, " R8 latency"}, lat, LAT);
    @(negedge clk);
    check({tag, " R8 pulse width"}, done_o, 0);
    check({tag, " R1 ready after end"}, smp_ready_o, 0);
    check({tag, " R2 select back to 0"}, sel_o, 0);
    i0 = idx0; i1 = idx1;
    extra = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (done_o || err_o) extra++;
    end
    check({tag, " R10 no further run"}, extra, 0);
    check({tag, " R1 no stray reads"}, idx0 + idx1, i0 + i1);
    check({tag, " R3 reads at select 0"}, idx0, r0);
    check({tag, " R2 reads at select 1"}, idx1, r1);
    check({tag, " R7 temperature"}, temp_o, t);
    last_temp = t;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 temp at reset", temp_o, 0);
    check("R11 done at reset", done_o, 0);
    check("R11 err at reset", err_o, 0);
    check("R11 ready at reset", smp_ready_o, 0);
    check("R11 sel at reset", sel_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(0, 1'b0, 0,   "R5 constant");
    run(1, 1'b1, 0,   "R1 sparse flags");
    run(2, 1'b1, 0,   "R7 negative ratio");
    run(3, 1'b0, 0,   "R6 zero second mean");
    run(4, 1'b0, 0,   "R4 discard give-up");
    run(6, 1'b1, 0,   "R7 equal means");
    run(1, 1'b0, 100, "R10 start while busy");
    run(5, 1'b0, 0,   "R9 collection watchdog");
    run(2, 1'b0, 0,   "R9 recovery");
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end
endmodule